// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block watches a handful of external request pins of a small microcontroller and turns the edges on them into latched request flags. Two pins have a trigger edge chosen by software. One pin fires on both edges. One pin is a quasi-interrupt that latches rising edges but never requests a vector. A small group of key inputs latch falling edges and likewise never request a vector.

The main vectored input is resynchronised and then passed through a noise filter clocked by a programmable sampling tick. The tick runs either every two instruction cycles or every 128 system clocks. The other pins pass through a plain two-flop synchroniser before their edge detector.

Software reaches the block through a one-cycle write port that selects one of three registers: mode, enable and clear. Flags stay set until software writes a 1 to their clear bit. Each vectored request output is its flag gated by an enable bit. Flag bit order: 0 = main filtered input, 1 = second selectable input, 2 = quasi rising input, 3 = both-edge input, 4+k = key input k.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset all flags, all enables and all vectored outputs are 0; both selectable inputs trigger on rising edges, and the filter runs on the fast tick.
- R2: Mode register (wr_sel=0) bit 0 selects the edge of the filtered input and bit 1 selects the edge of the second selectable input (0 = rising, 1 = falling); the other edge sets nothing.
- R3: The filtered input takes a new level only when it reads the same value on two consecutive sampling ticks. The tick comes every 2*INSTR_DIV clocks (8 by default) when mode bit 2 is 0 and every SLOW_PERIOD clocks (128) when it is 1. A pulse shorter than one tick period never sets flag 0.
- R4: The both-edge input sets flag 3 on a rising edge and also on a falling edge.
- R5: The quasi input sets flag 2 on rising edges only and never drives any vectored output.
- R6: Key input k sets flag 4+k on falling edges only; its rising edges set nothing.
- R7: A flag stays set until a write to wr_sel=2 with a 1 in that flag's bit position, which clears it on that clock edge.
- R8: When an edge and a clear of the same flag fall on the same clock edge, the flag stays set.
- R9: irq_vec_o bits 0, 1 and 2 follow flags 0, 1 and 3 ANDed with enable register (wr_sel=1) bits 0, 1 and 2.
- R10: A pin change sampled at one clock edge on an unfiltered input shows on its flag after the second clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int0_pin | input | 1 | Filtered, selectable-edge vectored input |
| int1_pin | input | 1 | Selectable-edge vectored input |
| int2_pin | input | 1 | Rising-edge quasi input |
| int4_pin | input | 1 | Both-edge vectored input |
| key_pin | input | NUM_KEYS | Falling-edge key inputs |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 enable, 2 clear |
| wr_data | input | REG_W | Write data |
| flag_o | output | NUM_KEYS+4 | Latched request flags |
| irq_vec_o | output | 3 | Gated vectored requests |

## Verification
The bench drives pulses on the filtered input that are shorter than one tick at both sampling rates. A filter that accepts on a single sample, or that ignores the rate select, would latch these glitches. It changes the edge select on each programmable input and checks that the opposite edge leaves its flag clear. The both-edge, quasi and key inputs are each driven through both polarities, which catches a polarity swap or a quasi source leaking onto a vectored output. A clear is timed to land on the same edge as a new detection: a design where the clear wins would show the flag empty.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2,
      EDGE_PROG = 2'd3
   } edge_kind_e;

   localparam int SYNC_DEPTH = 2;

   localparam logic [1:0] SEL_MODE   = 2'd0;
   localparam logic [1:0] SEL_ENABLE = 2'd1;
   localparam logic [1:0] SEL_CLEAR  = 2'd2;

   localparam int FLG_INT0 = 0;
   localparam int FLG_INT1 = 1;
   localparam int FLG_INT2 = 2;
   localparam int FLG_INT4 = 3;
   localparam int FLG_KEY0 = 4;

   localparam int MODE_INT0_FALL = 0;
   localparam int MODE_INT1_FALL = 1;
   localparam int MODE_INT0_SLOW = 2;
   localparam int MODE_W         = 3;

   localparam int NUM_VEC = 3;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_filter.sv
module irq_filter #(
   parameter int INSTR_DIV   = 4,
   parameter int SLOW_PERIOD = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic slow_sel_i,
   output logic lvl_o
);
   localparam int FAST_PERIOD = 2 * INSTR_DIV;
   localparam int MAX_PERIOD  = (SLOW_PERIOD > FAST_PERIOD) ? SLOW_PERIOD : FAST_PERIOD;
   localparam int CW          = (MAX_PERIOD > 2) ? $clog2(MAX_PERIOD) : 1;
   localparam logic [CW-1:0] FAST_M1 = CW'(FAST_PERIOD - 1);
   localparam logic [CW-1:0] SLOW_M1 = CW'(SLOW_PERIOD - 1);

   if (INSTR_DIV < 1) begin : g_bad_div
      $error("INSTR_DIV must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;
   logic          tick;
   logic          samp_q;
   logic          filt_q;

   assign limit = slow_sel_i ? SLOW_M1 : FAST_M1;
   assign tick  = (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         samp_q <= 1'b0;
         filt_q <= 1'b0;
      end else begin
         cnt_q <= tick ? '0 : cnt_q + 1'b1;
         if (tick) begin
            samp_q <= lvl_i;
            if (lvl_i == samp_q) filt_q <= lvl_i;
         end
      end
   end

   assign lvl_o = filt_q;
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det import irq_pkg::*; #(
   parameter edge_kind_e KIND = EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic fall_sel_i,
   output logic edge_o
);
   logic prev_q;
   logic rise;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign rise = lvl_i & ~prev_q;
   assign fall = ~lvl_i & prev_q;

   case (KIND)
      EDGE_RISE: begin : g_rise
         wire unused_sel = fall_sel_i;
         assign edge_o = rise;
      end
      EDGE_FALL: begin : g_fall
         wire unused_sel = fall_sel_i;
         assign edge_o = fall;
      end
      EDGE_BOTH: begin : g_both
         wire unused_sel = fall_sel_i;
         assign edge_o = rise | fall;
      end
      default: begin : g_prog
         assign edge_o = fall_sel_i ? fall : rise;
      end
   endcase
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   logic [N-1:0] flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~clr_i) | set_i;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect import irq_pkg::*; #(
   parameter int NUM_KEYS    = 3,
   parameter int REG_W       = 8,
   parameter int INSTR_DIV   = 4,
   parameter int SLOW_PERIOD = 128
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  int0_pin,
   input  logic                  int1_pin,
   input  logic                  int2_pin,
   input  logic                  int4_pin,
   input  logic [NUM_KEYS-1:0]   key_pin,
   input  logic                  wr_en,
   input  logic [1:0]            wr_sel,
   input  logic [REG_W-1:0]      wr_data,
   output logic [NUM_KEYS+3:0]   flag_o,
   output logic [NUM_VEC-1:0]    irq_vec_o
);
   localparam int NUM_FLAGS = FLG_KEY0 + NUM_KEYS;

   if (NUM_KEYS < 1) begin : g_bad_keys
      $error("NUM_KEYS must be at least 1");
   end
   if (NUM_FLAGS > REG_W) begin : g_bad_regw
      $error("REG_W too narrow for the flag vector");
   end
   if (SLOW_PERIOD < 2 * INSTR_DIV) begin : g_bad_slow
      $error("SLOW_PERIOD must not be shorter than the fast tick");
   end
   if (REG_W > NUM_FLAGS) begin : g_spare
      wire unused_hi = ^wr_data[REG_W-1:NUM_FLAGS];
   end

   logic [MODE_W-1:0]    mode_q;
   logic [NUM_VEC-1:0]   en_q;
   logic [NUM_FLAGS-1:0] set_vec;
   logic [NUM_FLAGS-1:0] clr_vec;
   logic [NUM_FLAGS-1:0] flags;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         en_q   <= '0;
      end else if (wr_en) begin
         if (wr_sel == SEL_MODE)   mode_q <= wr_data[MODE_W-1:0];
         if (wr_sel == SEL_ENABLE) en_q   <= wr_data[NUM_VEC-1:0];
      end
   end

   assign clr_vec = (wr_en && wr_sel == SEL_CLEAR) ? wr_data[NUM_FLAGS-1:0] : '0;

   // main input: synchroniser, sampling filter, selectable edge
   logic int0_sync;
   logic int0_filt;

   irq_sync #(.STAGES(SYNC_DEPTH)) u_sync0 (
      .clk(clk), .rst_n(rst_n), .d_i(int0_pin), .q_o(int0_sync));

   irq_filter #(.INSTR_DIV(INSTR_DIV), .SLOW_PERIOD(SLOW_PERIOD)) u_filt0 (
      .clk(clk), .rst_n(rst_n), .lvl_i(int0_sync),
      .slow_sel_i(mode_q[MODE_INT0_SLOW]), .lvl_o(int0_filt));

   irq_edge_det #(.KIND(EDGE_PROG)) u_edge0 (
      .clk(clk), .rst_n(rst_n), .lvl_i(int0_filt),
      .fall_sel_i(mode_q[MODE_INT0_FALL]), .edge_o(set_vec[FLG_INT0]));

   // unfiltered inputs share one structure; the edge kind is the variant
   localparam int NUM_PLAIN = 3 + NUM_KEYS;
   logic [NUM_PLAIN-1:0] plain_pin;
   logic [NUM_PLAIN-1:0] plain_lvl;
   logic [NUM_PLAIN-1:0] plain_edge;

   assign plain_pin = {key_pin, int4_pin, int2_pin, int1_pin};
   assign set_vec[NUM_FLAGS-1:FLG_INT1] = plain_edge;

   for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
      localparam edge_kind_e KIND_I = (i == 0) ? EDGE_PROG :
                                      (i == 1) ? EDGE_RISE :
                                      (i == 2) ? EDGE_BOTH : EDGE_FALL;
      irq_sync #(.STAGES(SYNC_DEPTH)) u_sync (
         .clk(clk), .rst_n(rst_n), .d_i(plain_pin[i]), .q_o(plain_lvl[i]));
      irq_edge_det #(.KIND(KIND_I)) u_edge (
         .clk(clk), .rst_n(rst_n), .lvl_i(plain_lvl[i]),
         .fall_sel_i(mode_q[MODE_INT1_FALL]), .edge_o(plain_edge[i]));
   end

   irq_flag_bank #(.N(NUM_FLAGS)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .flag_o(flags));

   assign flag_o    = flags;
   assign irq_vec_o = {flags[FLG_INT4], flags[FLG_INT1], flags[FLG_INT0]} & en_q;
endmodule

// File: rtl/irq_detect_chk.sv
module irq_detect_chk #(
   parameter int NUM_KEYS = 3,
   parameter int REG_W    = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                int2_pin,
   input logic [NUM_KEYS-1:0] key_pin,
   input logic                wr_en,
   input logic [1:0]          wr_sel,
   input logic [REG_W-1:0]    wr_data,
   input logic [NUM_KEYS+3:0] flag_o,
   input logic [2:0]          irq_vec_o
);
   logic [REG_W-1:0] flag_ext;
   logic [REG_W-1:0] clr_mask;
   logic [REG_W-1:0] keep_mask;
   logic [2:0]       vec_flags;

   assign flag_ext  = REG_W'(flag_o);
   assign clr_mask  = (wr_en && wr_sel == 2'd2) ? wr_data : '0;
   assign keep_mask = flag_ext & ~clr_mask;
   assign vec_flags = {flag_o[3], flag_o[1], flag_o[0]};

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (flag_o == '0 && irq_vec_o == '0));

   // R9
   vec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_vec_o & ~vec_flags) == 3'b000);

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_ext & $past(keep_mask)) == $past(keep_mask)));

   // R5
   quasi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o[2]) |-> $past(int2_pin, 2));

   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
      // R6
      key_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag_o[4+k]) |-> !$past(key_pin[k], 2));
   end
endmodule

bind ext_irq_detect irq_detect_chk #(.NUM_KEYS(NUM_KEYS), .REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .int2_pin(int2_pin), .key_pin(key_pin),
   .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .flag_o(flag_o), .irq_vec_o(irq_vec_o));

// File: tb/tb_ext_irq_detect.sv
module tb_ext_irq_detect;
   localparam int NK = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          int0_pin, int1_pin, int2_pin, int4_pin;
   logic [NK-1:0] key_pin;
   logic          wr_en;
   logic [1:0]    wr_sel;
   logic [7:0]    wr_data;
   logic [NK+3:0] flag_o;
   logic [2:0]    irq_vec_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   ext_irq_detect #(.NUM_KEYS(NK)) dut (
      .clk(clk), .rst_n(rst_n), .int0_pin(int0_pin), .int1_pin(int1_pin),
      .int2_pin(int2_pin), .int4_pin(int4_pin), .key_pin(key_pin),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .flag_o(flag_o), .irq_vec_o(irq_vec_o));

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_n(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] sel, logic [7:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic t_reset();
      chk("R1 flags after reset", int'(flag_o), 0);
      chk("R1 vectors after reset", int'(irq_vec_o), 0);
   endtask

   task automatic t_int0_fast();
      int0_pin = 1'b1; wait_n(4); int0_pin = 1'b0; wait_n(40);
      chk("R3 short pulse fast tick", int'(flag_o[0]), 0);
      int0_pin = 1'b1; wait_n(40); int0_pin = 1'b0; wait_n(40);
      chk("R1 R3 default rising accepted", int'(flag_o[0]), 1);
      chk("R9 disabled vector stays low", int'(irq_vec_o), 0);
   endtask

   task automatic t_enable();
      wr(2'd1, 8'h01);
      chk("R9 enabled vector", int'(irq_vec_o), 1);
      wr(2'd2, 8'h01);
      chk("R7 clear flag0", int'(flag_o[0]), 0);
      chk("R9 vector drops with flag", int'(irq_vec_o), 0);
   endtask

   task automatic t_int0_slow();
      wr(2'd0, 8'h04);
      int0_pin = 1'b1; wait_n(40); int0_pin = 1'b0; wait_n(300);
      chk("R3 slow tick rejects 40-clock pulse", int'(flag_o[0]), 0);
      int0_pin = 1'b1; wait_n(400); int0_pin = 1'b0; wait_n(300);
      chk("R3 slow tick accepts long pulse", int'(flag_o[0]), 1);
      wr(2'd2, 8'h01);
      wr(2'd0, 8'h00);
      wait_n(40);
   endtask

   task automatic t_int0_fall();
      wr(2'd0, 8'h01);
      int0_pin = 1'b1; wait_n(40);
      chk("R2 int0 falling mode ignores rise", int'(flag_o[0]), 0);
      int0_pin = 1'b0; wait_n(40);
      chk("R2 int0 falling mode", int'(flag_o[0]), 1);
      wr(2'd2, 8'h01);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_int1();
      int1_pin = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R10 not yet after second edge", int'(flag_o[1]), 0);
      @(negedge clk);
      chk("R10 flag after third edge", int'(flag_o[1]), 1);
      wr(2'd2, 8'h02);
      int1_pin = 1'b0; wait_n(5);
      chk("R2 int1 rising mode ignores fall", int'(flag_o[1]), 0);
      wr(2'd0, 8'h02);
      int1_pin = 1'b1; wait_n(5);
      chk("R2 int1 falling mode ignores rise", int'(flag_o[1]), 0);
      int1_pin = 1'b0; wait_n(5);
      chk("R2 int1 falling mode", int'(flag_o[1]), 1);
      wr(2'd2, 8'h02);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_int4();
      wr(2'd1, 8'h07);
      int4_pin = 1'b1; wait_n(5);
      chk("R4 rising edge", int'(flag_o[3]), 1);
      chk("R9 int4 vector", int'(irq_vec_o), 4);
      wr(2'd2, 8'h08);
      int4_pin = 1'b0; wait_n(5);
      chk("R4 falling edge", int'(flag_o[3]), 1);
      wr(2'd2, 8'h08);
   endtask

   task automatic t_int2();
      int2_pin = 1'b1; wait_n(5);
      chk("R5 quasi rising", int'(flag_o[2]), 1);
      chk("R5 quasi never vectored", int'(irq_vec_o), 0);
      wr(2'd2, 8'h04);
      int2_pin = 1'b0; wait_n(5);
      chk("R5 quasi ignores fall", int'(flag_o[2]), 0);
   endtask

   task automatic t_keys();
      for (int k = 0; k < NK; k++) begin
         key_pin[k] = 1'b0; wait_n(5);
         chk("R6 key falling sets own flag", int'(flag_o), 1 << (4 + k));
         wr(2'd2, 8'(1 << (4 + k)));
         key_pin[k] = 1'b1; wait_n(5);
         chk("R6 key rising ignored", int'(flag_o), 0);
      end
   endtask

   task automatic t_race();
      int1_pin = 1'b1; wait_n(5);
      int1_pin = 1'b0; wait_n(3);
      int1_pin = 1'b1;
      @(negedge clk); @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h02;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      chk("R8 set wins over clear", int'(flag_o[1]), 1);
      wr(2'd2, 8'h02);
      chk("R7 later clear works", int'(flag_o[1]), 0);
   endtask

   initial begin
      rst_n = 1'b0;
      int0_pin = 1'b0; int1_pin = 1'b0; int2_pin = 1'b0; int4_pin = 1'b0;
      key_pin = '1;
      wr_en = 1'b0; wr_sel = '0; wr_data = '0;
      wait_n(4);
      rst_n = 1'b1;
      wait_n(2);
      t_reset();
      t_int0_fast();
      t_enable();
      t_int0_slow();
      t_int0_fall();
      t_int1();
      t_int4();
      t_int2();
      t_keys();
      t_race();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule